// File: doc/BRIEF.md
# Instruction Bundle Unpacker and Slot Typer

This block takes one 128-bit instruction bundle per cycle on a valid/ready handshake. It splits the bundle into a 5-bit template code and three 41-bit instruction words. The template code is decoded into three pieces of information:

- a slot class for each word (memory, integer, floating point, branch or long);
- the positions of instruction-group stops, both the ones built into some templates and the optional one after the last slot;
- whether the code is one of the reserved values.

The three words leave in program order one cycle later. Each word carries its class, a stop-after bit and a per-slot valid bit. A front end places the block between bundle fetch and the per-slot opcode decoders, so each decoder can tell which unit a word is bound for and where a parallel issue group ends. The block does not look inside a slot: opcode decoding, execution, fetch and branch prediction are not part of it.

Template codes follow the rule code = 2 × base + tail-stop. The twelve base shapes have indices 0 to 11:

| Index | Shape | Built-in stop |
|---|---|---|
| 0 | M I I | none |
| 1 | M I I | after slot 1 |
| 2 | M L X | none |
| 3 | M M I | none |
| 4 | M M I | after slot 0 |
| 5 | M F I | none |
| 6 | M M F | none |
| 7 | M I B | none |
| 8 | M B B | none |
| 9 | B B B | none |
| 10 | M M B | none |
| 11 | M F B | none |

Codes 24 to 31 are reserved.

Top module: `bundle_unpacker`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: The template is bundle bits [4:0]. outSlots[0] is bits [45:5], outSlots[1] is bits [86:46] and outSlots[2] is bits [127:87].
- R3: outTypes[k] gives the class of slot k, encoded M=0, I=1, F=2, B=3, L=4. It follows the shape of base index code[4:1] in the table above.
- R4: outStop[2] equals code bit 0. outStop[1] is 1 only for base index 1. outStop[0] is 1 only for base index 4. At most one of outStop[1:0] is ever set.
- R5: For codes 24 to 31, outIllegal is 1, and outSlotValid, outStop, outTypes and outLongPair are all 0. For codes 0 to 23, outIllegal is 0 and outSlotValid is 3'b111.
- R6: outLongPair is 1 only for base index 2. In that case outTypes[1] is L (4) and outTypes[2] is I (1).
- R7: A bundle accepted at a rising edge (inValid and inReady both high) appears on the outputs after that edge, with outValid high.
- R8: While outValid is 1 and outReady is 0, every output holds its value and no new bundle is accepted.
- R9: inReady equals outReady OR NOT outValid, so the block accepts one bundle per cycle while the consumer keeps outReady high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input bundle offered |
| inReady | output | 1 | Block can take a bundle this cycle |
| inBundle | input | 128 | Bundle: template in [4:0], then three slots |
| outValid | output | 1 | Output set holds an unpacked bundle |
| outReady | input | 1 | Consumer takes the output set |
| outSlots | output | 3x41 | Slot words in program order |
| outTypes | output | 3x3 | Class of each slot |
| outStop | output | 3 | Stop after slot k |
| outSlotValid | output | 3 | Slot k holds a usable instruction |
| outLongPair | output | 1 | Slots 1 and 2 form one long-immediate instruction |
| outIllegal | output | 1 | Template code is reserved |

## Verification
The handshake assertions assume that the consumer drives outReady and the producer drives inValid and inBundle cleanly, changing them only between clock edges. The bench meets this by driving every input on the falling edge.

The decode assertions assume that any 5-bit code may arrive. The random stimulus therefore draws templates uniformly from all 32 codes, reserved ones included, and draws the slot bits freely.

The hold assertion assumes the consumer can stall for any number of cycles. Directed stall sequences exercise this while a second bundle waits at the input.

// File: rtl/bundle_pkg.sv
package bundle_pkg;
  localparam int SLOT_W     = 41;
  localparam int TMPL_W     = 5;
  localparam int NUM_SLOTS  = 3;
  localparam int TYPE_W     = 3;
  localparam int BUNDLE_W   = TMPL_W + NUM_SLOTS * SLOT_W;
  localparam int NUM_BASE   = 12;
  localparam int LEGAL_CODES = NUM_BASE * 2;

  localparam logic [TYPE_W-1:0] CLS_M = 3'd0;
  localparam logic [TYPE_W-1:0] CLS_I = 3'd1;
  localparam logic [TYPE_W-1:0] CLS_F = 3'd2;
  localparam logic [TYPE_W-1:0] CLS_B = 3'd3;
  localparam logic [TYPE_W-1:0] CLS_L = 3'd4;

  typedef struct packed {
    logic load;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [NUM_SLOTS-1:0][TYPE_W-1:0] types;
    logic [NUM_SLOTS-1:0]             stops;
    logic [NUM_SLOTS-1:0]             slotValid;
    logic                             longPair;
    logic                             illegal;
  } tmplInfo_t;

  function automatic tmplInfo_t decodeTemplate(input logic [TMPL_W-1:0] code);
    tmplInfo_t   d;
    logic [3:0]  base;
    base = code[TMPL_W-1:1];
    d = '0;
    if (int'(code) >= LEGAL_CODES) begin
      d.illegal = 1'b1;
    end else begin
      d.slotValid = '1;
      d.stops[2]  = code[0];
      d.types[0]  = CLS_M;
      case (base)
        4'd0, 4'd1: begin d.types[1] = CLS_I; d.types[2] = CLS_I; d.stops[1] = (base == 4'd1); end
        4'd2:       begin d.types[1] = CLS_L; d.types[2] = CLS_I; d.longPair = 1'b1; end
        4'd3, 4'd4: begin d.types[1] = CLS_M; d.types[2] = CLS_I; d.stops[0] = (base == 4'd4); end
        4'd5:       begin d.types[1] = CLS_F; d.types[2] = CLS_I; end
        4'd6:       begin d.types[1] = CLS_M; d.types[2] = CLS_F; end
        4'd7:       begin d.types[1] = CLS_I; d.types[2] = CLS_B; end
        4'd8:       begin d.types[1] = CLS_B; d.types[2] = CLS_B; end
        4'd9:       begin d.types[0] = CLS_B; d.types[1] = CLS_B; d.types[2] = CLS_B; end
        4'd10:      begin d.types[1] = CLS_M; d.types[2] = CLS_B; end
        default:    begin d.types[1] = CLS_F; d.types[2] = CLS_B; end
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/bundle_ctrl.sv
module bundle_ctrl
  import bundle_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  assign inReady      = outReady || !outValid;
  assign strobes.load = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)             outValid <= 1'b0;
    else if (strobes.load) outValid <= 1'b1;
    else if (outReady)     outValid <= 1'b0;
  end

  // R7: an accepted bundle is presented on the next cycle
  a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);
  // R8: a stalled output stays valid
  a_r8_stall_keeps_valid: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
endmodule

// File: rtl/bundle_dpath.sv
module bundle_dpath
  import bundle_pkg::*;
#(
  parameter int SLOTS  = NUM_SLOTS,
  parameter int SW     = SLOT_W,
  parameter int TW     = TMPL_W,
  localparam int BW    = TW + SLOTS * SW
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [BW-1:0]                 inBundle,
  output logic [SLOTS-1:0][SW-1:0]      outSlots,
  output logic [SLOTS-1:0][TYPE_W-1:0]  outTypes,
  output logic [SLOTS-1:0]              outStop,
  output logic [SLOTS-1:0]              outSlotValid,
  output logic                          outLongPair,
  output logic                          outIllegal
);
  logic [SLOTS-1:0][SW-1:0] slotWords;
  tmplInfo_t                info;

  for (genvar g = 0; g < SLOTS; g++) begin : g_split
    assign slotWords[g] = inBundle[TW + g*SW +: SW];
  end

  assign info = decodeTemplate(inBundle[TW-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSlots     <= '0;
      outTypes     <= '0;
      outStop      <= '0;
      outSlotValid <= '0;
      outLongPair  <= 1'b0;
      outIllegal   <= 1'b0;
    end else if (strobes.load) begin
      outSlots     <= slotWords;
      outTypes     <= info.types;
      outStop      <= info.stops;
      outSlotValid <= info.slotValid;
      outLongPair  <= info.longPair;
      outIllegal   <= info.illegal;
    end
  end

  // R4: never two built-in stops in one bundle
  a_r4_one_mid_stop: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outStop[1:0]) <= 1);
  // R5: reserved code gives no usable slot
  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> (outSlotValid == '0 && outStop == '0 && !outLongPair));
  // R6: long pair occupies slots 1 and 2 as L then I
  a_r6_long_pair_types: assert property (@(posedge clk) disable iff (!rstN)
    outLongPair |-> (outTypes[1] == CLS_L && outTypes[2] == CLS_I));
endmodule

// File: rtl/bundle_unpacker.sv
module bundle_unpacker
  import bundle_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  output logic                              inReady,
  input  logic [BUNDLE_W-1:0]               inBundle,
  output logic                              outValid,
  input  logic                              outReady,
  output logic [NUM_SLOTS-1:0][SLOT_W-1:0]  outSlots,
  output logic [NUM_SLOTS-1:0][TYPE_W-1:0]  outTypes,
  output logic [NUM_SLOTS-1:0]              outStop,
  output logic [NUM_SLOTS-1:0]              outSlotValid,
  output logic                              outLongPair,
  output logic                              outIllegal
);
  ctrlStrobes_t strobes;

  bundle_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  bundle_dpath #(.SLOTS(NUM_SLOTS), .SW(SLOT_W), .TW(TMPL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inBundle(inBundle),
    .outSlots(outSlots), .outTypes(outTypes), .outStop(outStop),
    .outSlotValid(outSlotValid), .outLongPair(outLongPair), .outIllegal(outIllegal)
  );

  // R8: stalled output set does not change
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outSlots) && $stable(outTypes) &&
                                 $stable(outStop) && $stable(outIllegal)));
  // R9: an empty output stage always accepts
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);
endmodule

// File: tb/bundle_unpacker_bench.sv
`timescale 1ns/1ps
module bundle_unpacker_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b1;
  logic [127:0] inBundle = '0;
  logic inReady, outValid, outLongPair, outIllegal;
  logic [2:0][40:0] outSlots;
  logic [2:0][2:0] outTypes;
  logic [2:0] outStop, outSlotValid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bundle_unpacker u_bundle_unpacker (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inBundle(inBundle),
    .outValid(outValid), .outReady(outReady), .outSlots(outSlots), .outTypes(outTypes),
    .outStop(outStop), .outSlotValid(outSlotValid), .outLongPair(outLongPair),
    .outIllegal(outIllegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected classes {slot2,slot1,slot0} per code (M=0 I=1 F=2 B=3 L=4)
  function automatic logic [8:0] expTypes(input logic [4:0] c);
    case (c[4:1])
      4'd0, 4'd1: return {3'd1, 3'd1, 3'd0};
      4'd2:       return {3'd1, 3'd4, 3'd0};
      4'd3, 4'd4: return {3'd1, 3'd0, 3'd0};
      4'd5:       return {3'd1, 3'd2, 3'd0};
      4'd6:       return {3'd2, 3'd0, 3'd0};
      4'd7:       return {3'd3, 3'd1, 3'd0};
      4'd8:       return {3'd3, 3'd3, 3'd0};
      4'd9:       return {3'd3, 3'd3, 3'd3};
      4'd10:      return {3'd3, 3'd0, 3'd0};
      4'd11:      return {3'd3, 3'd2, 3'd0};
      default:    return 9'd0;
    endcase
  endfunction

  function automatic logic [2:0] expStops(input logic [4:0] c);
    if (c >= 5'd24) return 3'b000;
    return {c[0], c[4:1] == 4'd1, c[4:1] == 4'd4};
  endfunction

  task automatic checkAll(input logic [127:0] b);
    logic [4:0] c;
    bit ill;
    c = b[4:0];
    ill = (c >= 5'd24);
    chk("R7 outValid", outValid, 1);
    chk("R2 slot0", outSlots[0], b[45:5]);
    chk("R2 slot1", outSlots[1], b[86:46]);
    chk("R2 slot2", outSlots[2], b[127:87]);
    chk("R3 types", outTypes, expTypes(c));
    chk("R4 stops", outStop, expStops(c));
    chk("R5 illegal", outIllegal, ill);
    chk("R5 slotValid", outSlotValid, ill ? 3'b000 : 3'b111);
    chk("R6 longPair", outLongPair, c[4:1] == 4'd2);
  endtask

  task automatic sendOne(input logic [127:0] b);
    @(negedge clk);
    inValid = 1'b1; inBundle = b; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkAll(b);
  endtask

  function automatic logic [127:0] rndBundle(input logic [4:0] c);
    logic [127:0] b;
    b = {$urandom, $urandom, $urandom, $urandom};
    b[4:0] = c;
    return b;
  endfunction

  initial begin
    logic [127:0] first, second;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 outValid reset", outValid, 0);
    chk("R1 inReady reset", inReady, 1);
    rstN = 1'b1;
    // directed: every code, legal and reserved
    for (int c = 0; c < 32; c++) sendOne(rndBundle(5'(c)));
    // field boundaries with walking patterns
    sendOne({41'h1FFFFFFFFFF, 41'h0, 41'h1FFFFFFFFFF, 5'd4});
    sendOne({41'h0, 41'h1FFFFFFFFFF, 41'h0, 5'd3});
    // R9: back-to-back acceptance with outReady high
    @(negedge clk);
    first = rndBundle(5'd8); second = rndBundle(5'd9);
    inValid = 1'b1; inBundle = first; outReady = 1'b1;
    @(negedge clk);
    chk("R9 ready while draining", inReady, 1);
    checkAll(first);
    inBundle = second;
    @(negedge clk);
    inValid = 1'b0;
    checkAll(second);
    @(negedge clk);
    chk("R9 empty after drain", outValid, 0);
    // R8: stall holds outputs and blocks input
    first = rndBundle(5'd3); second = rndBundle(5'd22);
    inValid = 1'b1; inBundle = first; outReady = 1'b0;
    @(negedge clk);
    inBundle = second;
    chk("R8 inReady low in stall", inReady, 0);
    @(negedge clk);
    @(negedge clk);
    checkAll(first);
    chk("R8 still blocked", inReady, 0);
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkAll(second);
    // random
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        outReady = 1'b1;
        @(negedge clk);
        chk("R9 idle", outValid, 0);
      end
      sendOne(rndBundle(5'($urandom_range(0, 31))));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule